// File: doc/BRIEF.md
# Shared Byte-Buffer Access Arbiter

This block decides which of several requesters gets the next access slot on a byte-wide DRAM buffer. A front-end path presents up to six sub-sources, and a microcontroller port, a host port and an error-correction engine also compete for the buffer. An internal refresh timer completes the set. Each requester holds a request level together with an address, a write flag and a write byte. The arbiter chooses one winner per slot. On the next clock edge it presents that winner's access to the downstream memory sequencer and pulses the winner's acknowledge. The requester drops or renews its request after it sees the acknowledge.

The order of service is not a plain ladder. The microcontroller sits between the upper and lower front-end sub-sources. Refresh beats the microcontroller only when no lower front-end sub-source is waiting. The host and ECC ports can run bursts. While a host burst is open, ECC cannot take a gap in it, but the front-end, the microcontroller and refresh can cut in at any beat.

Top module: `dram_buffer_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, accValid, accRefresh and every acknowledge are 0.
- R2: An access is issued (accValid=1 for one cycle) on the clock edge after a cycle in which seqReady=1, accValid=0 and some request or pending refresh is present. No access is issued while seqReady=0. accValid is never high in two consecutive cycles, so a backlog is served one access every two cycles.
- R3: When accValid=1, exactly one of feAck bits, ucAck, hostAck, eccAck, accRefresh is 1, and accAddr, accWdata and accWr carry the winner's inputs from the deciding cycle. With accValid=0, all acknowledges are 0.
- R4: Among front-end sub-sources, a lower feReq bit index wins (bit 0 highest).
- R5: Front-end sub-sources 0, 1 and 2 outrank the microcontroller. The microcontroller outranks sub-sources 3, 4 and 5.
- R6: A pending refresh loses to every front-end sub-source and beats host and ECC. It beats the microcontroller only when none of sub-sources 3 to 5 is requesting; otherwise the microcontroller goes first.
- R7: A refresh becomes pending every REFRESH_CLKS clock edges, counted from reset release. It is granted once and then cleared. Intervals that expire while it is still pending do not add further refresh grants.
- R8: The host port outranks ECC, and any front-end request outranks the host port.
- R9: After a host beat granted with hostLast=0, ECC receives no grant, even if the host request is low, until a host beat with hostLast=1 has been granted.
- R10: An open host or ECC burst is interrupted by any higher-ranked requester (front-end, microcontroller, refresh, or host over an ECC burst). The burst owner is served again after those requests are satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seqReady | input | 1 | Sequencer idle or current access finishing |
| feReq | input | NFE | Front-end sub-source requests, bit 0 highest |
| feWr | input | NFE | Write flag per front-end sub-source |
| feAddr | input | NFE*AW | Packed front-end addresses, sub-source i at [i*AW +: AW] |
| feWdata | input | NFE*DW | Packed front-end write bytes |
| ucReq | input | 1 | Microcontroller request |
| ucWr | input | 1 | Microcontroller write flag |
| ucAddr | input | AW | Microcontroller address |
| ucWdata | input | DW | Microcontroller write byte |
| hostReq | input | 1 | Host port request |
| hostLast | input | 1 | Current host beat closes the burst |
| hostWr | input | 1 | Host write flag |
| hostAddr | input | AW | Host address |
| hostWdata | input | DW | Host write byte |
| eccReq | input | 1 | ECC engine request |
| eccLast | input | 1 | Current ECC beat closes the burst |
| eccWr | input | 1 | ECC write flag |
| eccAddr | input | AW | ECC address |
| eccWdata | input | DW | ECC write byte |
| accValid | output | 1 | One-cycle access issue strobe to the sequencer |
| accRefresh | output | 1 | Issued access is a refresh cycle |
| accWr | output | 1 | Issued access is a write |
| accAddr | output | AW | Issued access address |
| accWdata | output | DW | Issued access write byte |
| feAck | output | NFE | Front-end sub-source acknowledge |
| ucAck | output | 1 | Microcontroller acknowledge |
| hostAck | output | 1 | Host acknowledge |
| eccAck | output | 1 | ECC acknowledge |

## Verification
Most internal faults in this block appear at the ports within two clock cycles of the deciding request pattern. A corrupted refresh counter or pending flag moves the refresh acknowledge off the cycle that is one edge after each interval boundary, or produces a second refresh after a long stall. A stale host burst owner either starves ECC well after the last host beat, or lets an ECC acknowledge appear in a gap of an open burst. A wrong priority path shows up as a reordered acknowledge sequence when many requests are released together.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int FE_MAX = 8;
  localparam int FE_IW  = $clog2(FE_MAX);

  typedef enum logic [2:0] {
    SRC_NONE, SRC_FE, SRC_UC, SRC_HOST, SRC_ECC, SRC_REF
  } src_e;

  typedef enum logic [1:0] {OWN_NONE, OWN_HOST, OWN_ECC} burstOwner_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             issue;
    src_e             src;
    logic [FE_IW-1:0] feIdx;
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NFE          = 6,
  parameter int FE_ABOVE_UC  = 3,
  parameter int REFRESH_CLKS = 529
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           seqReady,
  input  logic           accBusy,
  input  logic [NFE-1:0] feReq,
  input  logic           ucReq,
  input  logic           hostReq,
  input  logic           hostLast,
  input  logic           eccReq,
  input  logic           eccLast,
  output arbStrobe_t     stb
);
  localparam int CW = $clog2(REFRESH_CLKS);
  localparam logic [CW-1:0] REF_TOP = CW'(REFRESH_CLKS - 1);
  localparam logic [NFE-1:0] HI_MASK = NFE'((1 << FE_ABOVE_UC) - 1);

  logic [CW-1:0]    refCnt;
  logic             refPend;
  burstOwner_e      owner;
  logic [FE_IW-1:0] feIdx;
  logic             hiAny, loAny;
  src_e             win;

  always_comb begin
    feIdx = '0;
    for (int i = NFE - 1; i >= 0; i--) begin
      if (feReq[i]) feIdx = FE_IW'(i);
    end
    hiAny = |(feReq & HI_MASK);
    loAny = |(feReq & ~HI_MASK);
    if (hiAny)                        win = SRC_FE;
    else if (refPend && !loAny)       win = SRC_REF;
    else if (ucReq)                   win = SRC_UC;
    else if (loAny)                   win = SRC_FE;
    else if (refPend)                 win = SRC_REF;
    else if (hostReq)                 win = SRC_HOST;
    else if (eccReq && owner != OWN_HOST) win = SRC_ECC;
    else                              win = SRC_NONE;
    stb.issue = seqReady && !accBusy && (win != SRC_NONE);
    stb.src   = win;
    stb.feIdx = feIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      refPend <= 1'b0;
    end else begin
      if (stb.issue && win == SRC_REF) refPend <= 1'b0;
      if (refCnt == REF_TOP) begin
        refCnt  <= '0;
        refPend <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner <= OWN_NONE;
    end else if (stb.issue) begin
      if (win == SRC_HOST) begin
        if (!hostLast)              owner <= OWN_HOST;
        else if (owner == OWN_HOST) owner <= OWN_NONE;
      end else if (win == SRC_ECC) begin
        owner <= eccLast ? OWN_NONE : OWN_ECC;
      end
    end
  end
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int NFE = 6,
  parameter int AW  = 22,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        stb,
  input  logic [NFE-1:0]    feWr,
  input  logic [NFE*AW-1:0] feAddr,
  input  logic [NFE*DW-1:0] feWdata,
  input  logic              ucWr,
  input  logic [AW-1:0]     ucAddr,
  input  logic [DW-1:0]     ucWdata,
  input  logic              hostWr,
  input  logic [AW-1:0]     hostAddr,
  input  logic [DW-1:0]     hostWdata,
  input  logic              eccWr,
  input  logic [AW-1:0]     eccAddr,
  input  logic [DW-1:0]     eccWdata,
  output logic              accValid,
  output logic              accRefresh,
  output logic              accWr,
  output logic [AW-1:0]     accAddr,
  output logic [DW-1:0]     accWdata,
  output logic [NFE-1:0]    feAck,
  output logic              ucAck,
  output logic              hostAck,
  output logic              eccAck
);
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selData;
  logic          selWr;

  always_comb begin
    selAddr = '0;
    selData = '0;
    selWr   = 1'b0;
    case (stb.src)
      SRC_FE: begin
        for (int i = 0; i < NFE; i++) begin
          if (stb.feIdx == FE_IW'(i)) begin
            selAddr = feAddr[i*AW +: AW];
            selData = feWdata[i*DW +: DW];
            selWr   = feWr[i];
          end
        end
      end
      SRC_UC:   begin selAddr = ucAddr;   selData = ucWdata;   selWr = ucWr;   end
      SRC_HOST: begin selAddr = hostAddr; selData = hostWdata; selWr = hostWr; end
      SRC_ECC:  begin selAddr = eccAddr;  selData = eccWdata;  selWr = eccWr;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValid   <= 1'b0;
      accRefresh <= 1'b0;
      accWr      <= 1'b0;
      accAddr    <= '0;
      accWdata   <= '0;
      feAck      <= '0;
      ucAck      <= 1'b0;
      hostAck    <= 1'b0;
      eccAck     <= 1'b0;
    end else begin
      accValid   <= stb.issue;
      accRefresh <= stb.issue && stb.src == SRC_REF;
      ucAck      <= stb.issue && stb.src == SRC_UC;
      hostAck    <= stb.issue && stb.src == SRC_HOST;
      eccAck     <= stb.issue && stb.src == SRC_ECC;
      for (int i = 0; i < NFE; i++) begin
        feAck[i] <= stb.issue && stb.src == SRC_FE && stb.feIdx == FE_IW'(i);
      end
      if (stb.issue) begin
        accAddr  <= selAddr;
        accWdata <= selData;
        accWr    <= selWr;
      end
    end
  end
endmodule

// File: rtl/dram_buffer_arbiter.sv
module dram_buffer_arbiter
  import arb_pkg::*;
#(
  parameter int NFE          = 6,
  parameter int AW           = 22,
  parameter int DW           = 8,
  parameter int FE_ABOVE_UC  = 3,
  parameter int REFRESH_CLKS = 529
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqReady,
  input  logic [NFE-1:0]    feReq,
  input  logic [NFE-1:0]    feWr,
  input  logic [NFE*AW-1:0] feAddr,
  input  logic [NFE*DW-1:0] feWdata,
  input  logic              ucReq,
  input  logic              ucWr,
  input  logic [AW-1:0]     ucAddr,
  input  logic [DW-1:0]     ucWdata,
  input  logic              hostReq,
  input  logic              hostLast,
  input  logic              hostWr,
  input  logic [AW-1:0]     hostAddr,
  input  logic [DW-1:0]     hostWdata,
  input  logic              eccReq,
  input  logic              eccLast,
  input  logic              eccWr,
  input  logic [AW-1:0]     eccAddr,
  input  logic [DW-1:0]     eccWdata,
  output logic              accValid,
  output logic              accRefresh,
  output logic              accWr,
  output logic [AW-1:0]     accAddr,
  output logic [DW-1:0]     accWdata,
  output logic [NFE-1:0]    feAck,
  output logic              ucAck,
  output logic              hostAck,
  output logic              eccAck
);
  arbStrobe_t stb;

  arb_ctrl #(
    .NFE(NFE), .FE_ABOVE_UC(FE_ABOVE_UC), .REFRESH_CLKS(REFRESH_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .seqReady(seqReady), .accBusy(accValid),
    .feReq(feReq), .ucReq(ucReq), .hostReq(hostReq), .hostLast(hostLast),
    .eccReq(eccReq), .eccLast(eccLast), .stb(stb)
  );

  arb_dpath #(.NFE(NFE), .AW(AW), .DW(DW)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .feWr(feWr), .feAddr(feAddr), .feWdata(feWdata),
    .ucWr(ucWr), .ucAddr(ucAddr), .ucWdata(ucWdata),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .eccWr(eccWr), .eccAddr(eccAddr), .eccWdata(eccWdata),
    .accValid(accValid), .accRefresh(accRefresh), .accWr(accWr),
    .accAddr(accAddr), .accWdata(accWdata),
    .feAck(feAck), .ucAck(ucAck), .hostAck(hostAck), .eccAck(eccAck)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NFE = 6
) (
  input logic           clk,
  input logic           rstN,
  input logic           seqReady,
  input logic [NFE-1:0] feReq,
  input logic           hostReq,
  input logic           hostLast,
  input logic           accValid,
  input logic           accRefresh,
  input logic [NFE-1:0] feAck,
  input logic           ucAck,
  input logic           hostAck,
  input logic           eccAck
);
  logic hostLastQ, hostOpenM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostLastQ <= 1'b0;
      hostOpenM <= 1'b0;
    end else begin
      hostLastQ <= hostLast;
      if (hostAck) hostOpenM <= !hostLastQ;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $countones({feAck, ucAck, hostAck, eccAck, accRefresh}) == 1); // R3
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> ({feAck, ucAck, hostAck, eccAck, accRefresh} == '0)); // R3
  AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> !accValid); // R2
  AST_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $past(seqReady)); // R2
  AST_HOST_BELOW_FE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> !$past(|feReq)); // R8
  AST_ECC_BELOW_HOST: assert property (@(posedge clk) disable iff (!rstN)
    eccAck |-> !$past(hostReq)); // R8
  AST_NO_ECC_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    eccAck |-> !hostOpenM); // R9
endmodule

bind dram_buffer_arbiter arb_checker #(.NFE(NFE)) uChk (.*);

// File: tb/sim_dram_buffer_arbiter.sv
`timescale 1ns/1ps
module sim_dram_buffer_arbiter;
  localparam int NFE = 6;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int REF = 200;
  localparam int C_UC = 6, C_HOST = 7, C_ECC = 8, C_REF = 9;

  logic clk = 1'b0, rstN = 1'b0, seqReady = 1'b0;
  logic [NFE-1:0] feReq = '0, feWr = '1;
  logic [NFE*AW-1:0] feAddr;
  logic [NFE*DW-1:0] feWdata;
  logic ucReq = 0, ucWr = 0, hostReq = 0, hostLast = 1, hostWr = 1;
  logic eccReq = 0, eccLast = 1, eccWr = 0;
  logic [AW-1:0] ucAddr = 'h200, hostAddr = 'h300, eccAddr = 'h400;
  logic [DW-1:0] ucWdata = 'h20, hostWdata = 'h30, eccWdata = 'h40;
  logic accValid, accRefresh, accWr, ucAck, hostAck, eccAck;
  logic [AW-1:0] accAddr;
  logic [DW-1:0] accWdata;
  logic [NFE-1:0] feAck;

  int checks = 0, errors = 0, cyc = 0, logN = 0;
  int logCode[64];
  int logCyc[64];
  int gcnt[10];

  always #4 clk = ~clk;

  dram_buffer_arbiter #(.NFE(NFE), .AW(AW), .DW(DW), .FE_ABOVE_UC(3),
                        .REFRESH_CLKS(REF)) u0 (.*);

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitPhase(input int ph);
    do tick(); while (cyc % REF != ph);
  endtask

  // grant monitor: logs winners, checks payload, drops the served request
  always @(negedge clk) begin
    if (rstN && accValid) begin
      int code, nOn, expAddr, expData, expWr;
      code = -1; nOn = 0;
      for (int i = 0; i < NFE; i++) if (feAck[i]) begin code = i; nOn++; end
      if (ucAck)      begin code = C_UC;   nOn++; end
      if (hostAck)    begin code = C_HOST; nOn++; end
      if (eccAck)     begin code = C_ECC;  nOn++; end
      if (accRefresh) begin code = C_REF;  nOn++; end
      check(nOn == 1, "R3", "single winner", nOn, 1);
      if (code >= 0 && code < C_REF) begin
        if (code < NFE) begin
          expAddr = 'h100 + code; expData = 'h10 + code; expWr = 1;
          feReq[code] = 1'b0;
        end else if (code == C_UC) begin
          expAddr = ucAddr; expData = ucWdata; expWr = ucWr; ucReq = 0;
        end else if (code == C_HOST) begin
          expAddr = hostAddr; expData = hostWdata; expWr = hostWr; hostReq = 0;
        end else begin
          expAddr = eccAddr; expData = eccWdata; expWr = eccWr; eccReq = 0;
        end
        check(accAddr == AW'(expAddr), "R3", "address", accAddr, expAddr);
        check(accWdata == DW'(expData), "R3", "write byte", accWdata, expData);
        check(accWr == expWr[0], "R3", "write flag", accWr, expWr);
      end
      if (code >= 0) begin
        gcnt[code]++;
        if (logN < 64) begin logCode[logN] = code; logCyc[logN] = cyc; logN++; end
      end
    end else if (rstN) begin
      if (|{feAck, ucAck, hostAck, eccAck, accRefresh})
        check(0, "R3", "acknowledge without access", 1, 0);
    end
  end

  task automatic clearLog();
    logN = 0;
    for (int i = 0; i < 10; i++) gcnt[i] = 0;
  endtask

  // release a set of requests together with a pending refresh; compare order
  task automatic runOrder(input string req, input logic [NFE-1:0] fe,
                          input bit uc, input bit host, input bit ecc,
                          input int e[10], input int n);
    int c0;
    seqReady = 0;
    waitPhase(100);
    feReq = fe; ucReq = uc; hostReq = host; hostLast = 1;
    eccReq = ecc; eccLast = 1;
    clearLog();
    waitPhase(5);
    check(logN == 0, "R2", "no grant while seqReady low", logN, 0);
    seqReady = 1; c0 = cyc;
    tick(40);
    check(logN == n, req, "grant count", logN, n);
    check(logCyc[0] == c0 + 1, "R2", "first grant cycle", logCyc[0], c0 + 1);
    for (int k = 0; k < n && k < logN; k++) begin
      check(logCode[k] == e[k], req, $sformatf("order slot %0d", k), logCode[k], e[k]);
      if (k > 0) check(logCyc[k] - logCyc[k-1] == 2, "R2", "backlog spacing",
                       logCyc[k] - logCyc[k-1], 2);
    end
  endtask

  task automatic testReset();
    check({accValid, accRefresh, feAck, ucAck, hostAck, eccAck} == '0, "R1",
          "outputs in reset", accValid, 0);
    tick();
    rstN = 1;
    tick();
    check({accValid, accRefresh, feAck, ucAck, hostAck, eccAck} == '0, "R1",
          "outputs after reset", accValid, 0);
  endtask

  task automatic testFullOrder();
    // R4 R5 R6 R8
    runOrder("R5", 6'h3F, 1, 1, 1, '{0, 1, 2, C_UC, 3, 4, 5, C_REF, C_HOST, C_ECC}, 10);
  endtask

  task automatic testRefreshVsUc();
    runOrder("R6", 6'h00, 1, 1, 1, '{C_REF, C_UC, C_HOST, C_ECC, 0, 0, 0, 0, 0, 0}, 4);
  endtask

  task automatic testLowFe();
    // R4 R6: lower front-end beats refresh; refresh beats host
    runOrder("R4", 6'b110010, 0, 1, 0, '{1, 4, 5, C_REF, C_HOST, 0, 0, 0, 0, 0}, 5);
  endtask

  task automatic testHostBurst();
    seqReady = 1;
    waitPhase(20);
    clearLog();
    hostLast = 0; hostAddr = 'h300; hostReq = 1;
    eccLast = 1; eccReq = 1;
    for (int b = 0; b < 3; b++) begin
      for (int w = 0; w < 20 && gcnt[C_HOST] < b + 1; w++) tick();
      check(gcnt[C_HOST] == b + 1, "R9", "host beat granted", gcnt[C_HOST], b + 1);
      if (b < 2) begin
        tick(4);
        check(gcnt[C_ECC] == 0, "R9", "ecc held in host burst gap", gcnt[C_ECC], 0);
        hostLast = (b == 1); hostAddr = AW'('h301 + b); hostReq = 1;
      end
    end
    tick(6);
    check(gcnt[C_ECC] == 1, "R9", "ecc served after last beat", gcnt[C_ECC], 1);
    hostLast = 1;
  endtask

  task automatic testPreempt();
    seqReady = 1;
    waitPhase(20);
    clearLog();
    hostLast = 0; hostReq = 1;
    tick(6);
    ucReq = 1; feReq = 6'b100000; hostReq = 1; hostLast = 1;
    tick(20);
    check(logN == 4, "R10", "host preempt count", logN, 4);
    check(logCode[1] == C_UC, "R10", "uc cuts host burst", logCode[1], C_UC);
    check(logCode[2] == 5, "R10", "fe cuts host burst", logCode[2], 5);
    check(logCode[3] == C_HOST, "R10", "host burst resumes", logCode[3], C_HOST);
    waitPhase(20);
    clearLog();
    eccLast = 0; eccReq = 1;
    tick(6);
    hostReq = 1; hostLast = 1; eccReq = 1; eccLast = 1;
    tick(20);
    check(logN == 3, "R10", "ecc preempt count", logN, 3);
    check(logCode[1] == C_HOST, "R10", "host cuts ecc burst", logCode[1], C_HOST);
    check(logCode[2] == C_ECC, "R10", "ecc burst resumes", logCode[2], C_ECC);
  endtask

  task automatic testRefreshOnce();
    seqReady = 0;
    waitPhase(100);
    waitPhase(5); waitPhase(5); waitPhase(5);
    clearLog();
    seqReady = 1;
    tick(60);
    check(gcnt[C_REF] == 1, "R7", "one refresh after long stall", gcnt[C_REF], 1);
    check(logN == 1, "R7", "nothing else granted", logN, 1);
  endtask

  task automatic testRefreshPeriod();
    seqReady = 1;
    clearLog();
    waitPhase(50); waitPhase(50); waitPhase(50);
    check(logN == 3, "R7", "refresh per interval", logN, 3);
    for (int k = 0; k < logN && k < 3; k++) begin
      check(logCode[k] == C_REF, "R7", "refresh code", logCode[k], C_REF);
      check(logCyc[k] % REF == 1, "R7", "refresh phase", logCyc[k] % REF, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < NFE; i++) begin
      feAddr[i*AW +: AW]  = AW'('h100 + i);
      feWdata[i*DW +: DW] = DW'('h10 + i);
    end
    testReset();
    testFullOrder();
    testRefreshVsUc();
    testLowFe();
    testHostBurst();
    testPreempt();
    testRefreshOnce();
    testRefreshPeriod();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule